// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a service line driven by a processor and asks the reset generator for a reset when the line stops moving. Every rising or falling transition on the service line restarts an internal cycle counter. If the counter reaches the selected period with no transition in between, the block emits a one-cycle timeout request. While the system reset is active, the counter is held at zero. It starts counting again when that reset is released, so a freshly reset processor always gets a full period before its first service is due.

Four period lengths can be selected. Each is a parameter given in clock cycles, so the defaults can follow real millisecond and second values at the design clock while a bench uses short ones. The service line and the "line floating" flag come from outside the clock domain. Both pass through a synchroniser before any decision is made. When the line is reported floating, the block services itself at seven eighths of the selected period, which in effect switches the watchdog off. After a timeout the block goes quiet and waits for the reset it requested before it starts watching again.

Top module: `edgewd_top`

## Requirements
- R1: While `rst` is high, `timeoutPulse` is 0 and the counter is cleared. If nothing else clears the counter, the first request is raised after the P-th rising clock edge that follows the last edge at which `rst` was sampled high (P = selected period).
- R2: A rising or a falling change on `svcIn` clears the counter. A change first sampled at clock edge k clears the counter at edge k+2, and the next request then follows edge k+2+P.
- R3: A service line held steadily high or low never clears the counter, so a request still arrives P edges after the last clear.
- R4: While `sysRstActive` is high, the counter stays at 0 and no request is raised. Counting restarts on release, and the request follows the P-th edge after the last edge at which `sysRstActive` was sampled high.
- R5: `timeoutPulse` is high for exactly one clock cycle per timeout.
- R6: `periodSel` codes 0, 1, 2 and 3 select PERIOD0, PERIOD1, PERIOD2 and PERIOD3 cycles, which are ascending.
- R7: If `periodSel` is changed to a period that the running count already meets or exceeds, the request is raised after the very next clock edge.
- R8: After a request, further edges on `svcIn` are ignored and no further request is raised until `sysRstActive` has been sampled high. The normal watch then resumes.
- R9: While `svcFloat` is high, the block clears its own counter every 7/8 of the selected period, so no request is ever raised.
- R10: Once `svcFloat` returns low and no edges arrive, a request is raised within P+4 cycles.
- R11: A service pulse only one clock cycle wide is detected. Its two edges clear the counter, and the request follows the P-th edge after the clear caused by the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, fast enough to sample the shortest service pulse |
| rst | input | 1 | Synchronous block reset, active high |
| svcIn | input | 1 | Service line from the processor, asynchronous |
| svcFloat | input | 1 | High when the service line is undriven, asynchronous |
| periodSel | input | 2 | Period select, 0 = shortest to 3 = longest |
| sysRstActive | input | 1 | High while the system reset is asserted |
| timeoutPulse | output | 1 | One-cycle timeout request to the reset generator |

## Verification
A timeout request appears after the P-th edge following the last clear. A clear caused by a service edge lands two edges after the change is first sampled, because of the synchroniser and the edge register. A clear from either reset lands at the last edge where that reset is seen high. A period cut below the running count fires after the next edge. The bench keeps its own cycle count, stamped just after each rising edge. It drives inputs on falling edges, works out from these latencies the exact cycle in which each request must appear, and checks that the request occurs in that cycle, once, and not earlier. Checks that expect no request count every cycle of the quiet window, and floating-line release is checked against a bounded window.

// File: rtl/edgewd_pkg.sv
package edgewd_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clr;   // force the counter to zero
    logic inc;   // advance the counter by one
  } wdStrobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic svcEdge;   // synchronised service line changed level
    logic selfDue;   // floating line: self-service point reached
    logic limitHit;  // count has met the selected period
  } wdStatus_t;

  typedef enum logic {
    ST_WATCH = 1'b0,   // counting, edges honoured
    ST_FIRED = 1'b1    // request issued, waiting for system reset
  } wdState_e;

  localparam int NUM_PERIODS = 4;

  function automatic longint unsigned pickPeriod(
    input int idx,
    input longint unsigned p0, input longint unsigned p1,
    input longint unsigned p2, input longint unsigned p3);
    case (idx)
      0:       return p0;
      1:       return p1;
      2:       return p2;
      default: return p3;
    endcase
  endfunction

  function automatic longint unsigned maxPeriod(
    input longint unsigned p0, input longint unsigned p1,
    input longint unsigned p2, input longint unsigned p3);
    longint unsigned m;
    m = p0;
    if (p1 > m) m = p1;
    if (p2 > m) m = p2;
    if (p3 > m) m = p3;
    return m;
  endfunction

endpackage

// File: rtl/edgewd_datapath.sv
module edgewd_datapath
  import edgewd_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter longint unsigned PERIOD0     = 64'd787500,
  parameter longint unsigned PERIOD1     = 64'd12750000,
  parameter longint unsigned PERIOD2     = 64'd200000000,
  parameter longint unsigned PERIOD3     = 64'd3200000000,
  parameter int              CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             svcIn,
  input  logic             svcFloat,
  input  logic [1:0]       periodSel,
  input  wdStrobe_t        strobe,
  output wdStatus_t        status,
  output logic [CNT_W-1:0] cntVal
);

  localparam int LAST = SYNC_STAGES - 1;

  // Per-selection compare points: terminal count and self-service point.
  logic [CNT_W-1:0] limTbl  [NUM_PERIODS];
  logic [CNT_W-1:0] selfTbl [NUM_PERIODS];

  for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_tbl
    localparam longint unsigned PER = pickPeriod(i, PERIOD0, PERIOD1, PERIOD2, PERIOD3);
    assign limTbl[i]  = CNT_W'(PER - 1);
    assign selfTbl[i] = CNT_W'((PER * 7) / 8 - 1);
  end

  // Synchronisers for the two asynchronous inputs.
  logic [LAST:0] svcSync;
  logic [LAST:0] fltSync;
  logic          svcPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      svcSync <= '0;
      fltSync <= '0;
      svcPrev <= 1'b0;
    end else begin
      svcSync <= {svcSync[LAST-1:0], svcIn};
      fltSync <= {fltSync[LAST-1:0], svcFloat};
      svcPrev <= svcSync[LAST];
    end
  end

  // Watchdog counter.
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst)             cntQ <= '0;
    else if (strobe.clr) cntQ <= '0;
    else if (strobe.inc) cntQ <= cntQ + CNT_W'(1);
  end

  logic [CNT_W-1:0] limNow;
  logic [CNT_W-1:0] selfNow;

  always_comb begin
    limNow          = limTbl[periodSel];
    selfNow         = selfTbl[periodSel];
    status.svcEdge  = svcSync[LAST] ^ svcPrev;
    status.selfDue  = fltSync[LAST] && (cntQ >= selfNow);
    status.limitHit = (cntQ >= limNow);
  end

  assign cntVal = cntQ;

endmodule

// File: rtl/edgewd_control.sv
module edgewd_control
  import edgewd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sysRstActive,
  input  wdStatus_t status,
  output wdStrobe_t strobe,
  output logic      timeoutPulse
);

  wdState_e stateQ;
  logic     fireNow;
  logic     watching;

  always_comb begin
    watching   = (stateQ == ST_WATCH);
    // System reset always clears. Edges and self-service only while watching.
    strobe.clr = sysRstActive || (watching && (status.svcEdge || status.selfDue));
    strobe.inc = watching;
    fireNow    = watching && !strobe.clr && status.limitHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ       <= ST_WATCH;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= fireNow;
      if (fireNow)           stateQ <= ST_FIRED;
      else if (sysRstActive) stateQ <= ST_WATCH;
    end
  end

endmodule

// File: rtl/edgewd_top.sv
module edgewd_top
  import edgewd_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter longint unsigned PERIOD0     = 64'd787500,
  parameter longint unsigned PERIOD1     = 64'd12750000,
  parameter longint unsigned PERIOD2     = 64'd200000000,
  parameter longint unsigned PERIOD3     = 64'd3200000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       svcIn,
  input  logic       svcFloat,
  input  logic [1:0] periodSel,
  input  logic       sysRstActive,
  output logic       timeoutPulse
);

  localparam int CNT_W = $clog2(maxPeriod(PERIOD0, PERIOD1, PERIOD2, PERIOD3) + 1);

  wdStrobe_t        ctrlStrobe;
  wdStatus_t        dpStatus;
  logic [CNT_W-1:0] cntVal;

  edgewd_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .PERIOD0(PERIOD0), .PERIOD1(PERIOD1),
    .PERIOD2(PERIOD2), .PERIOD3(PERIOD3),
    .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .svcIn(svcIn), .svcFloat(svcFloat),
    .periodSel(periodSel), .strobe(ctrlStrobe), .status(dpStatus),
    .cntVal(cntVal)
  );

  edgewd_control ctl_i (
    .clk(clk), .rst(rst), .sysRstActive(sysRstActive),
    .status(dpStatus), .strobe(ctrlStrobe), .timeoutPulse(timeoutPulse)
  );

endmodule

// File: rtl/edgewd_checker.sv
module edgewd_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sysRstActive,
  input logic             svcEdge,
  input logic             timeoutPulse,
  input logic [CNT_W-1:0] cntVal
);

  // Set once a request has gone out, cleared by system reset.
  logic armedQ;
  always_ff @(posedge clk) begin
    if (rst || sysRstActive) armedQ <= 1'b0;
    else if (timeoutPulse)   armedQ <= 1'b1;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!timeoutPulse && cntVal == '0));

  // R5
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |=> !timeoutPulse);

  // R4
  a_r4_sysrst_holds: assert property (@(posedge clk) disable iff (rst)
    sysRstActive |=> (cntVal == '0 && !timeoutPulse));

  // R8
  a_r8_quiet_after_fire: assert property (@(posedge clk) disable iff (rst)
    armedQ |-> !timeoutPulse);

  // R2
  a_r2_edge_clears: assert property (@(posedge clk) disable iff (rst)
    (svcEdge && !armedQ && !timeoutPulse) |=> (cntVal == '0));

endmodule

bind edgewd_top edgewd_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .sysRstActive(sysRstActive),
  .svcEdge(dpStatus.svcEdge), .timeoutPulse(timeoutPulse), .cntVal(cntVal)
);

// File: tb/edgewd_top_tb_top.sv
`timescale 1ns/1ps
module edgewd_top_tb_top;

  localparam longint unsigned P0 = 40;
  localparam longint unsigned P1 = 64;
  localparam longint unsigned P2 = 100;
  localparam longint unsigned P3 = 160;

  logic       clk = 1'b0;
  logic       rst;
  logic       svcIn;
  logic       svcFloat;
  logic [1:0] periodSel;
  logic       sysRstActive;
  logic       timeoutPulse;

  always #4 clk = ~clk;  // 125 MHz

  edgewd_top #(.SYNC_STAGES(2), .PERIOD0(P0), .PERIOD1(P1),
               .PERIOD2(P2), .PERIOD3(P3)) dut_i (
    .clk(clk), .rst(rst), .svcIn(svcIn), .svcFloat(svcFloat),
    .periodSel(periodSel), .sysRstActive(sysRstActive),
    .timeoutPulse(timeoutPulse)
  );

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  longint lastPulse = -1;
  int     pulseCnt = 0;
  longint lastClr = 0;
  int     pcBase = 0;
  bit     done = 1'b0;

  // Cycle stamp and request monitor, sampled 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    if (timeoutPulse === 1'b1) begin
      pulseCnt  = pulseCnt + 1;
      lastPulse = cyc;
    end
  end

  function automatic longint perOf(input int sel);
    case (sel)
      0: return longint'(P0);
      1: return longint'(P1);
      2: return longint'(P2);
      default: return longint'(P3);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Assert system reset for n cycles and release it; sets the clear baseline.
  task automatic sysRelease(input int n);
    sysRstActive = 1'b1;
    tick(n);
    sysRstActive = 1'b0;
    lastClr = cyc;
    pcBase  = pulseCnt;
  endtask

  task automatic toggleSvc();
    svcIn   = ~svcIn;
    lastClr = cyc + 3;
  endtask

  // Exactly one request since the baseline, stamped at cycle e, one cycle wide.
  task automatic expectPulseAt(input longint e, input string req);
    while (cyc < e + 1) tick(1);
    check(pulseCnt == pcBase + 1, {req, " count"}, pulseCnt - pcBase, 1);
    check(lastPulse == e, {req, " cycle"}, lastPulse, e);
    pcBase = pulseCnt;
  endtask

  task automatic expectQuiet(input int n, input string req);
    int pc0;
    pc0 = pulseCnt;
    tick(n);
    check(pulseCnt == pc0, req, pulseCnt - pc0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; svcIn = 1'b0; svcFloat = 1'b0; periodSel = 2'd0; sysRstActive = 1'b0;
    void'($urandom(32'd20240611));
    tick(3);
    // R1: reset state and first request counted from reset release
    check(timeoutPulse == 1'b0, "R1 reset output", timeoutPulse, 0);
    rst = 1'b0;
    lastClr = cyc;
    pcBase  = pulseCnt;
    expectPulseAt(lastClr + perOf(0), "R1 first request");

    // R8: edges ignored after a request
    for (int i = 0; i < 4; i++) begin
      tick(5);
      toggleSvc();
    end
    expectQuiet(int'(2 * P0), "R8 quiet after request");

    // R6: each period select code
    for (int s = 0; s < 4; s++) begin
      periodSel = 2'(s);
      sysRelease(3);
      expectPulseAt(lastClr + perOf(s), "R6 period select");
    end

    // R4: held system reset gives no request, release restarts count
    periodSel = 2'd1;
    sysRstActive = 1'b1;
    expectQuiet(int'(3 * P3), "R4 held reset quiet");
    sysRelease(1);
    expectPulseAt(lastClr + perOf(1), "R4 count after release");

    // R2 / R3: one edge clears, then a steady level does not
    periodSel = 2'd2;
    sysRelease(2);
    tick(20);
    toggleSvc();
    expectPulseAt(lastClr + perOf(2), "R3 steady level times out");

    // R11: one-cycle service pulse
    periodSel = 2'd0;
    if (svcIn) begin svcIn = 1'b0; tick(4); end
    sysRelease(2);
    tick(10);
    svcIn = 1'b1;
    tick(1);
    toggleSvc();
    expectPulseAt(lastClr + perOf(0), "R11 narrow pulse");

    // R7: period cut below the running count
    periodSel = 2'd3;
    sysRelease(2);
    tick(100);
    periodSel = 2'd0;
    expectPulseAt(cyc + 1, "R7 shortened period");

    // R9 / R10: floating line self-service
    svcFloat = 1'b1;
    sysRelease(2);
    expectQuiet(int'(6 * P0), "R9 floating no request");
    svcFloat = 1'b0;
    begin
      int pc0;
      pc0 = pulseCnt;
      tick(int'(P0) + 4);
      check(pulseCnt == pc0 + 1, "R10 request after float ends", pulseCnt - pc0, 1);
    end

    // R2: random service gaps below the period, then a silent stretch
    for (int it = 0; it < 12; it++) begin
      int sel;
      int nTog;
      sel = int'($urandom % 4);
      periodSel = 2'(sel);
      sysRelease(1 + int'($urandom % 3));
      nTog = 1 + int'($urandom % 8);
      for (int k = 0; k < nTog; k++) begin
        tick(1 + int'($urandom % (perOf(sel) - 4)));
        toggleSvc();
      end
      expectPulseAt(lastClr + perOf(sel), "R2 random service");
    end

    // R1: block reset while stopped restarts the watch
    periodSel = 2'd1;
    rst = 1'b1;
    tick(2);
    check(timeoutPulse == 1'b0, "R1 reset mid-run", timeoutPulse, 0);
    rst = 1'b0;
    lastClr = cyc;
    pcBase  = pulseCnt;
    expectPulseAt(lastClr + perOf(1), "R1 restart after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule